// File: doc/BRIEF.md
# Flash Sector Map and Boot Lock Guard

This block sits beside the command logic of a small parallel flash memory. It maps a 17-bit byte address to one of five erase sectors: a 16 KiB boot sector, two 8 KiB parameter sectors and two main sectors of 32 KiB and 64 KiB. Each program or erase request is then judged against a boot-sector write lock. For an erase request it produces the set of sectors that should be cleared. A parameter picks the layout. With the bottom-boot layout the boot sector sits at the lowest addresses. With the top-boot layout every sector is mirrored to the upper end of the address space.

The lock bit is set by a request and stays set through the functional reset. Only the power-on initialisation input clears it. An override input lifts the lock for as long as it is held. A sector erase aimed at the boot sector never erases anything. Instead it makes the block busy for a short fixed number of cycles, which models the quick return to read mode, and every request made in that window is refused. In identification mode, the lock state can be read on data bit 0 at offset 2 of the boot sector.

Top module: `sector_guard`

## Requirements
- R1: With TOP_BOOT=0, `sector_idx` reports 0 (boot) for 0x00000–0x03FFF, 1 for 0x04000–0x05FFF, 2 for 0x06000–0x07FFF, 3 for 0x08000–0x0FFFF and 4 for 0x10000–0x1FFFF. This holds whether or not a request is present.
- R2: With TOP_BOOT=1, `sector_idx` reports 0 (boot) for 0x1C000–0x1FFFF, 1 for 0x1A000–0x1BFFF, 2 for 0x18000–0x19FFF, 3 for 0x10000–0x17FFF and 4 for 0x00000–0x0FFFF.
- R3: A sector erase (`req_kind`=1) to a non-boot sector is permitted. Bit i of `erase_mask` stands for sector i. Sector 1 gives 5'b00010, sector 2 gives 5'b00100, sector 4 gives 5'b10000, and sector 3 gives 5'b01110, which clears both parameter sectors with it.
- R4: A sector erase aimed at the boot sector gives `permit`=0 and `erase_mask`=0. From the next cycle `skip_busy` is high for exactly RET_CYC cycles, and every request during that window gives `permit`=0.
- R5: A chip erase (`req_kind`=2) is permitted. Its mask is 5'b11111 when the lock is clear or overridden, and 5'b11110 when the lock is set and not overridden.
- R6: A byte program (`req_kind`=0) is permitted in any sector unless it targets the boot sector while the lock is set and `override` is low.
- R7: While `override` is high, boot-sector program and chip erase behave as if the lock were clear. The lock takes effect again in the same cycle that `override` falls.
- R8: A set-lock request (`req_kind`=3) is permitted, and `lock_status` reads 1 from the next cycle on.
- R9: `lock_status` keeps its value through `rst_n` low. Only `por_n` low clears it.
- R10: `id_lock_bit` equals `lock_status` when `id_mode` is high and the address is the boot sector base plus 2 (0x00002 bottom, 0x1C002 top). Otherwise it is 0.
- R11: With `req_valid` low, `permit` is 0 and `erase_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous |
| por_n | input | 1 | Power-on initialisation, active low, clears the lock |
| addr | input | 17 | Byte address of the request or read |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 set lock |
| override | input | 1 | Lifts the boot lock while high |
| id_mode | input | 1 | Identification read mode |
| sector_idx | output | 3 | Sector that holds `addr` |
| erase_mask | output | 5 | Sectors the current erase request clears |
| permit | output | 1 | The current request is allowed |
| lock_status | output | 1 | Boot lock bit |
| skip_busy | output | 1 | Return window after a boot sector erase |
| id_lock_bit | output | 1 | Data bit 0 of an identification read |

## Verification
Two events can meet in one cycle. The first is a change of `override` in the same cycle as a boot-sector program or chip erase under the lock. The bench drops `override` at the edge where the request is applied and expects the refusal and the 5'b11110 mask in that same cycle. The second is a request that arrives while the boot-erase return window is open. The bench issues a program to the boot sector in the first busy cycle, expects it to be refused, and then counts the busy cycles against RET_CYC. Both layouts run side by side on shared stimulus, so the bench compares a boot hit in one layout with a main-sector hit in the other on every step.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int AW   = 17;
  localparam int NSEC = 5;
  localparam int SW   = 3;

  localparam logic [1:0] K_PROG = 2'd0;
  localparam logic [1:0] K_SECT = 2'd1;
  localparam logic [1:0] K_CHIP = 2'd2;
  localparam logic [1:0] K_LOCK = 2'd3;

  localparam logic [SW-1:0] SEC_BOOT  = 3'd0;
  localparam logic [SW-1:0] SEC_PAR1  = 3'd1;
  localparam logic [SW-1:0] SEC_PAR2  = 3'd2;
  localparam logic [SW-1:0] SEC_MAIN1 = 3'd3;
  localparam logic [SW-1:0] SEC_MAIN2 = 3'd4;

  // low-boot layout: upper address bits pick the sector
  function automatic logic [SW-1:0] sec_low(input logic [AW-1:0] a);
    if (a[16])               return SEC_MAIN2;
    else if (a[15])          return SEC_MAIN1;
    else if (a[14:13] == 2'b11) return SEC_PAR2;
    else if (a[14:13] == 2'b10) return SEC_PAR1;
    else                     return SEC_BOOT;
  endfunction

  // high-boot layout: mirror image of the low one
  function automatic logic [SW-1:0] sec_high(input logic [AW-1:0] a);
    if (!a[16])              return SEC_MAIN2;
    else if (!a[15])         return SEC_MAIN1;
    else if (a[14])          return SEC_BOOT;
    else if (a[13])          return SEC_PAR1;
    else                     return SEC_PAR2;
  endfunction

  // sectors cleared by a sector erase of s
  function automatic logic [NSEC-1:0] sect_mask(input logic [SW-1:0] s);
    case (s)
      SEC_PAR1:  return 5'b00010;
      SEC_PAR2:  return 5'b00100;
      SEC_MAIN1: return 5'b01110;
      SEC_MAIN2: return 5'b10000;
      default:   return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/sgd_decode.sv
module sgd_decode
  import sgd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          id_mode,
  output logic [SW-1:0] sector,
  output logic          id_hit
);
  localparam logic [AW-1:0] BOOT_BASE = TOP_BOOT ? 17'h1C000 : 17'h00000;
  localparam logic [AW-1:0] ID_ADDR   = BOOT_BASE + 17'd2;

  generate
    if (TOP_BOOT) begin : g_high
      assign sector = sec_high(addr);
    end else begin : g_low
      assign sector = sec_low(addr);
    end
  endgenerate

  assign id_hit = id_mode && (addr == ID_ADDR);
endmodule

// File: rtl/sgd_policy.sv
module sgd_policy
  import sgd_pkg::*;
(
  input  logic            active,
  input  logic [1:0]      kind,
  input  logic [SW-1:0]   sector,
  input  logic            lock,
  input  logic            override,
  output logic            permit,
  output logic [NSEC-1:0] mask,
  output logic            boot_skip,
  output logic            set_lock
);
  logic guard;
  logic is_boot;
  assign guard   = lock && !override;
  assign is_boot = (sector == SEC_BOOT);

  always_comb begin
    permit    = 1'b0;
    mask      = '0;
    boot_skip = 1'b0;
    set_lock  = 1'b0;
    if (active) begin
      case (kind)
        K_PROG: permit = !(is_boot && guard);
        K_SECT: begin
          if (is_boot) begin
            boot_skip = 1'b1;
          end else begin
            permit = 1'b1;
            mask   = sect_mask(sector);
          end
        end
        K_CHIP: begin
          permit = 1'b1;
          mask   = guard ? 5'b11110 : 5'b11111;
        end
        default: begin
          permit   = 1'b1;
          set_lock = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sgd_lock_bit.sv
module sgd_lock_bit (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  output logic lock
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   lock <= 1'b0;
    else if (set) lock <= 1'b1;
  end
endmodule

// File: rtl/sgd_skip_timer.sv
module sgd_skip_timer #(
  parameter int RET_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RET_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RET_CYC);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sgd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0,
  parameter int RET_CYC  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_n,
  input  logic [AW-1:0]   addr,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            override,
  input  logic            id_mode,
  output logic [SW-1:0]   sector_idx,
  output logic [NSEC-1:0] erase_mask,
  output logic            permit,
  output logic            lock_status,
  output logic            skip_busy,
  output logic            id_lock_bit
);
  logic          active;
  logic          boot_skip;
  logic          set_lock;
  logic          id_hit;
  logic [SW-1:0] sector;

  assign active = req_valid && rst_n && por_n && !skip_busy;

  sgd_decode #(.TOP_BOOT(TOP_BOOT)) u_dec (
    .addr(addr), .id_mode(id_mode), .sector(sector), .id_hit(id_hit)
  );

  sgd_policy u_pol (
    .active(active), .kind(req_kind), .sector(sector), .lock(lock_status),
    .override(override), .permit(permit), .mask(erase_mask),
    .boot_skip(boot_skip), .set_lock(set_lock)
  );

  sgd_lock_bit u_lock (
    .clk(clk), .por_n(por_n), .set(set_lock), .lock(lock_status)
  );

  sgd_skip_timer #(.RET_CYC(RET_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(boot_skip), .busy(skip_busy)
  );

  assign sector_idx  = sector;
  assign id_lock_bit = id_hit && lock_status;
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
  import sgd_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            por_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic            override,
  input logic [SW-1:0]   sector_idx,
  input logic [NSEC-1:0] erase_mask,
  input logic            permit,
  input logic            lock_status,
  input logic            skip_busy
);
  logic live;
  assign live = req_valid && !skip_busy;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    lock_status |=> lock_status); // R9

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (live && req_kind == K_LOCK) |=> lock_status); // R8

  AST_BOOT_SKIP: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (live && req_kind == K_SECT && sector_idx == SEC_BOOT) |=> skip_busy); // R4

  AST_BOOT_NOP: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (req_kind == K_SECT && sector_idx == SEC_BOOT) |-> (!permit && erase_mask == '0)); // R4

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    skip_busy |-> !permit); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !req_valid |-> (!permit && erase_mask == '0)); // R11

  AST_PROG_GUARD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (req_kind == K_PROG && sector_idx == SEC_BOOT && lock_status && !override)
      |-> !permit); // R6

  AST_CHIP_KEEP_BOOT: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (req_kind == K_CHIP && lock_status && !override) |-> !erase_mask[0]); // R5
endmodule

bind sector_guard sgd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .req_valid(req_valid),
  .req_kind(req_kind), .override(override), .sector_idx(sector_idx),
  .erase_mask(erase_mask), .permit(permit), .lock_status(lock_status),
  .skip_busy(skip_busy)
);

// File: tb/sim_sector_guard.sv
module sim_sector_guard;
  localparam int RET = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic [16:0] addr = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        override = 1'b0;
  logic        id_mode = 1'b0;

  logic [2:0] sec0, sec1;
  logic [4:0] msk0, msk1;
  logic       pm0, pm1, lk0, lk1, bz0, bz1, id0, id1;

  int total = 0;
  int bad = 0;
  bit lock_m = 1'b0;

  always #5 clk = ~clk;

  sector_guard #(.TOP_BOOT(1'b0), .RET_CYC(RET)) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .req_valid(req_valid),
    .req_kind(req_kind), .override(override), .id_mode(id_mode),
    .sector_idx(sec0), .erase_mask(msk0), .permit(pm0), .lock_status(lk0),
    .skip_busy(bz0), .id_lock_bit(id0));

  sector_guard #(.TOP_BOOT(1'b1), .RET_CYC(RET)) u1 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .req_valid(req_valid),
    .req_kind(req_kind), .override(override), .id_mode(id_mode),
    .sector_idx(sec1), .erase_mask(msk1), .permit(pm1), .lock_status(lk1),
    .skip_busy(bz1), .id_lock_bit(id1));

  function automatic int exp_sec(bit top, int a);
    int b;
    b = top ? (32'h1FFFF - a) : a;  // mirror for the high-boot layout
    if (b < 32'h04000) return 0;
    if (b < 32'h06000) return 1;
    if (b < 32'h08000) return 2;
    if (b < 32'h10000) return 3;
    return 4;
  endfunction

  function automatic int exp_mask(bit top, int a, int k, bit lk, bit ov);
    int s;
    s = exp_sec(top, a);
    if (k == 2) return (lk && !ov) ? 30 : 31;
    if (k != 1) return 0;
    case (s)
      1: return 2;
      2: return 4;
      3: return 14;
      4: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_perm(bit top, int a, int k, bit lk, bit ov);
    int s;
    s = exp_sec(top, a);
    if (k == 0) return (s == 0 && lk && !ov) ? 0 : 1;
    if (k == 1) return (s == 0) ? 0 : 1;
    return 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare both layouts against the model for the request now applied
  task automatic judge(input string req);
    int k;
    k = req_kind;
    if (req_valid) begin
      chk(req, pm0, exp_perm(1'b0, addr, k, lock_m, override));
      chk(req, msk0, exp_mask(1'b0, addr, k, lock_m, override));
      chk(req, pm1, exp_perm(1'b1, addr, k, lock_m, override));
      chk(req, msk1, exp_mask(1'b1, addr, k, lock_m, override));
    end else begin
      chk(req, {pm0, msk0, pm1, msk1}, 0);
    end
  endtask

  task automatic apply(input int a, input bit v, input int k);
    @(negedge clk);
    addr = a[16:0];
    req_valid = v;
    req_kind = k[1:0];
    #1;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R9 por clears lock", {lk0, lk1}, 0);
    chk("R11 reset quiet", {pm0, msk0, bz0, bz1}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;

    // R1 R2 sweep, idle and program, and erase on non-boot addresses
    for (int i = 0; i < 64; i++) begin
      int a;
      a = i * 32'h800 + 32'h123;
      apply(a, 1'b0, 0);
      chk("R1 low map", sec0, exp_sec(1'b0, a));
      chk("R2 high map", sec1, exp_sec(1'b1, a));
      judge("R11 idle");
      apply(a, 1'b1, 0);
      judge("R6 program unlocked");
      apply(a, 1'b1, 2);
      judge("R5 chip erase unlocked");
      if (a >= 32'h04000 && a < 32'h1C000) begin
        apply(a, 1'b1, 1);
        judge("R3 sector erase");
      end
    end

    // R3 exact boundaries
    apply(32'h07FFF, 1'b1, 1); chk("R3 par2 top edge", msk0, 5'b00100);
    apply(32'h08000, 1'b1, 1); chk("R3 main1 merged", msk0, 5'b01110);
    apply(32'h17FFF, 1'b1, 1); chk("R3 high main1 merged", msk1, 5'b01110);
    apply(32'h1BFFF, 1'b1, 1); chk("R3 high par1", msk1, 5'b00010);

    // R4 boot sector erase on the low layout, main2 on the high one
    apply(32'h00010, 1'b1, 1);
    chk("R4 boot erase refused", {pm0, msk0}, 0);
    chk("R4 other layout erases main2", msk1, 5'b10000);
    apply(32'h00010, 1'b1, 0);
    chk("R4 busy after boot erase", bz0, 1);
    chk("R4 request refused while busy", pm0, 0);
    chk("R4 high layout not busy", bz1, 0);
    req_valid = 1'b0;
    begin
      int n;
      n = 1;
      @(negedge clk);
      while (bz0 && n < 50) begin
        n++;
        @(negedge clk);
      end
      chk("R4 busy length", n, RET);
    end

    // R8 set lock
    apply(32'h00000, 1'b1, 3);
    chk("R8 set lock permitted", {pm0, pm1}, 2'b11);
    apply(32'h00000, 1'b0, 0);
    chk("R8 lock visible", {lk0, lk1}, 2'b11);
    lock_m = 1'b1;

    // R6 R5 locked behaviour
    apply(32'h02000, 1'b1, 0);
    chk("R6 boot program refused", pm0, 0);
    judge("R6 locked program");
    apply(32'h1E000, 1'b1, 0);
    chk("R6 high boot program refused", pm1, 0);
    apply(32'h05000, 1'b1, 0);
    chk("R6 non-boot program allowed", pm0, 1);
    apply(32'h05000, 1'b1, 2);
    chk("R5 locked chip erase", {msk0, msk1}, {5'b11110, 5'b11110});

    // R7 override
    @(negedge clk);
    override = 1'b1;
    addr = 17'h02000; req_valid = 1'b1; req_kind = 2'd0;
    #1;
    chk("R7 override boot program", pm0, 1);
    apply(32'h02000, 1'b1, 2);
    chk("R7 override chip erase", msk0, 5'b11111);
    @(negedge clk);
    override = 1'b0;  // falls in the same cycle as the request
    req_kind = 2'd0;
    #1;
    chk("R7 release refuses at once", pm0, 0);
    req_kind = 2'd2;
    #1;
    chk("R7 release restores mask", msk0, 5'b11110);
    judge("R7 after release");

    // R10 identification read
    apply(32'h00002, 1'b0, 0);
    chk("R10 id off", {id0, id1}, 0);
    id_mode = 1'b1;
    #1;
    chk("R10 low id bit", {id0, id1}, 2'b10);
    apply(32'h1C002, 1'b0, 0);
    chk("R10 high id bit", {id0, id1}, 2'b01);
    apply(32'h1C003, 1'b0, 0);
    chk("R10 wrong offset", {id0, id1}, 0);
    id_mode = 1'b0;

    // R9 functional reset keeps the lock, power-on clears it
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R9 lock survives rst_n", {lk0, lk1}, 2'b11);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    #1;
    lock_m = 1'b0;
    chk("R9 lock cleared by por_n", {lk0, lk1}, 0);
    apply(32'h02000, 1'b1, 2);
    chk("R5 chip erase after clear", msk0, 5'b11111);
    apply(32'h02000, 1'b0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule